// File: doc/BRIEF.md
# Byte-Serial Preset Counter Channel

This block is a single 24-bit up/down counter channel. A host reaches it through two 8-bit ports. The data port moves 24-bit values one byte at a time, lowest byte first. The control/status port takes command bytes when written and returns a flag byte when read. The counter cannot be written directly. The host fills a preset register byte by byte and then commands a transfer of that preset into the counter. To read the count, the host first freezes it into an output latch and then reads the latch out byte by byte.

Counting is driven by single-cycle count strobes that arrive already filtered, each with a direction bit. Four count modes are available: free running, range limit, non-recycle and modulo-N. Two toggle flags invert on overflow and underflow, and their exclusive OR serves as a 25th count bit. An index input can reload the preset into the counter, either on an edge or in step with a count strobe. A transfer command copies the low preset byte to an output that programs the input filter's clock divider.

The command state machine has two run states. `ST_RUN` accepts strobes. `ST_HALT` is entered from `ST_RUN` on a non-recycle wrap and ignores strobes. Any counter load returns the machine from `ST_HALT` to `ST_RUN`. The byte pointer steps through positions 0, 1 and 2 and then returns to 0.

Top module: `preset_counter_chan`

## Requirements
- R1: Out of reset, the status byte reads 0x00, the counter and output latch read 0, and `psc_out` is 0. A control write is decoded by bits [7:5]: 000 is reset/load, 001 is counter mode, 010 is I/O control and 011 is index control. Any write with bit 7 set is ignored.
- R2: Data-port writes store bytes of the preset, lowest byte first. The byte pointer advances on every data-port access and returns to byte 0 after the third byte. A reset/load write with bit 0 set (0x01) returns the pointer to byte 0.
- R3: A reset/load write with bits [4:3] = 10 (0x10) copies the counter into the output latch. Data-port reads return the latch bytes, lowest first, and do not refresh the latch. The code 0x11 also resets the pointer.
- R4: A reset/load write with bits [4:3] = 01 (0x08) loads the preset into the counter. Bits [2:1] = 01 (0x02) clears the counter.
- R5: When counter mode bits [2:1] = 0 (normal), the count wraps between 0xFFFFFF and 0. An overflow inverts status bit 1 (carry toggle) and an underflow inverts status bit 0 (borrow toggle). The exclusive OR of the two toggles forms count bit 24.
- R6: In range-limit mode (bits [2:1] = 1), counting up holds once the count reaches or exceeds the preset, counting down holds at 0, and neither toggle changes.
- R7: In non-recycle mode (bits [2:1] = 2), the count wraps as in normal mode and inverts the toggle. It then ignores further strobes until the counter is loaded.
- R8: In modulo-N mode (bits [2:1] = 3), counting up from a count at or above the preset gives 0 and inverts the carry toggle. Counting down from 0 gives the preset and inverts the borrow toggle.
- R9: I/O control bit 0 enables count strobes, and strobes arriving while it is 0 change neither the count nor the flags. Status bit 5 holds the direction of the last accepted strobe, where 1 means up.
- R10: When I/O control bit 1 is 0, an index event loads the preset into the counter. When it is 1, the index is ignored. Index control bit 1 selects the active level: 1 makes the rising edge the event, 0 makes the falling edge the event.
- R11: Index control bit 0 selects synchronous index. It is kept only if counter mode bits [4:3] are nonzero at that write, and a counter-mode write with bits [4:3] = 0 clears it. In synchronous index, the event is a count strobe that arrives while the index is at its active level, and that strobe loads the preset instead of counting.
- R12: Reset/load 0x04 clears both toggles. Reset/load 0x06 clears the noise error flag (status bit 4). `noise_in` sets that flag, and setting wins over a clear in the same cycle.
- R13: Reset/load bits [4:3] = 11 (0x18) copies the low preset byte to `psc_out`. The code 0x19 also resets the pointer.
- R14: A counter load in the same cycle as a strobe takes priority, and the strobe is lost. A latch transfer in the same cycle as a strobe captures the count from before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Port write strobe |
| rd_en | input | 1 | Port read strobe |
| port_sel | input | 1 | 0 = data port, 1 = control/status port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the selected port |
| cnt_pulse | input | 1 | Single-cycle count strobe |
| cnt_dir | input | 1 | Strobe direction, 1 = up |
| index_in | input | 1 | Index input |
| noise_in | input | 1 | Noise detect from the input filter |
| psc_out | output | 8 | Filter clock divider value |

## Verification
A count strobe can arrive in the same cycle as a control command that loads the counter or captures it into the latch. The noise detect can also coincide with the command that clears the error flag. The bench drives each of these pairs in one shared cycle. It judges the outcome from the counter, the latch and the status byte read afterwards: a load wins over the strobe, the latch holds the count from before the strobe, and the error flag stays set. Separate sweeps run every count mode across both wrap points and check each step against an arithmetic model.

// File: rtl/chan_pkg.sv
package chan_pkg;
    typedef enum logic [2:0] {
        SEL_RLD = 3'b000,
        SEL_CMR = 3'b001,
        SEL_IOR = 3'b010,
        SEL_IDR = 3'b011
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_RANGE  = 2'd1,
        MODE_NOREC  = 2'd2,
        MODE_MODN   = 2'd3
    } cnt_mode_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_e;
endpackage

// File: rtl/chan_byte_ptr.sv
module chan_byte_ptr #(
    parameter int NBYTES = 3,
    localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (clr)
            ptr <= '0;
        else if (step)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/chan_index_det.sv
module chan_index_det (
    input  logic clk,
    input  logic rst_n,
    input  logic index_in,
    input  logic pol_high,
    input  logic sync_mode,
    input  logic strobe,
    output logic event_o
);
    logic active, prev_active;

    assign active = pol_high ? index_in : ~index_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_active <= 1'b1;
        else
            prev_active <= active;
    end

    assign event_o = sync_mode ? (active & strobe) : (active & ~prev_active);
endmodule

// File: rtl/chan_count_core.sv
module chan_count_core
    import chan_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic         dir_up,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] preset,
    input  logic         load_zero,
    input  logic         load_preset,
    input  logic         clr_toggles,
    output logic [W-1:0] cnt,
    output logic         bt,
    output logic         ct,
    output logic         ud,
    output logic         halted
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    run_state_e   st_q, st_nxt;
    logic [W-1:0] cnt_nxt;
    logic         bt_nxt, ct_nxt, ud_nxt, up_lim, dn_lim, at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
            cnt  <= '0;
            bt   <= 1'b0;
            ct   <= 1'b0;
            ud   <= 1'b0;
        end else begin
            st_q <= st_nxt;
            cnt  <= cnt_nxt;
            bt   <= bt_nxt;
            ct   <= ct_nxt;
            ud   <= ud_nxt;
        end
    end

    assign up_lim = (mode == MODE_RANGE || mode == MODE_MODN) ? (cnt >= preset) : (cnt == MAXV);
    assign dn_lim = (cnt == '0);
    assign at_lim = dir_up ? up_lim : dn_lim;

    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt;
        bt_nxt  = bt;
        ct_nxt  = ct;
        ud_nxt  = ud;
        if (load_zero) begin
            cnt_nxt = '0;
            st_nxt  = ST_RUN;
        end else if (load_preset) begin
            cnt_nxt = preset;
            st_nxt  = ST_RUN;
        end else if (strobe) begin
            ud_nxt = dir_up;
            unique case (st_q)
                ST_HALT: st_nxt = ST_HALT;
                ST_RUN: begin
                    if (!at_lim) begin
                        cnt_nxt = dir_up ? cnt + 1'b1 : cnt - 1'b1;
                    end else if (mode != MODE_RANGE) begin
                        if (dir_up) ct_nxt = ~ct;
                        else        bt_nxt = ~bt;
                        if (mode == MODE_MODN)
                            cnt_nxt = dir_up ? '0 : preset;
                        else
                            cnt_nxt = dir_up ? '0 : MAXV;
                        if (mode == MODE_NOREC)
                            st_nxt = ST_HALT;
                    end
                end
                default: st_nxt = ST_RUN;
            endcase
        end
        if (clr_toggles) begin
            bt_nxt = 1'b0;
            ct_nxt = 1'b0;
        end
    end

    assign halted = (st_q == ST_HALT);
endmodule

// File: rtl/preset_counter_chan.sv
module preset_counter_chan
    import chan_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             port_sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             cnt_pulse,
    input  logic             cnt_dir,
    input  logic             index_in,
    input  logic             noise_in,
    output logic [BUS_W-1:0] psc_out
);
    localparam int NBYTES = CNT_W / BUS_W;
    localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic             ctrl_wr, data_wr, data_rd;
    logic             rld_go, cmr_go, ior_go, idr_go;
    logic             bp_clr, zero_go, flag_go, err_go, pre_go, latch_go, psc_go;
    logic [PTR_W-1:0] bp;
    cnt_mode_e        mode_q;
    logic [1:0]       quad_q;
    logic             io_en, io_nidx, idx_pol, idx_sync, err_q;
    logic             strobe_ok, idx_evt, load_pre;
    logic [CNT_W-1:0] preset_q, latch_q, cnt_q;
    logic             bt_q, ct_q, ud_q, halt_q;
    logic [BUS_W-1:0] latch_b [NBYTES];
    logic [BUS_W-1:0] status;

    assign ctrl_wr = wr_en & port_sel;
    assign data_wr = wr_en & ~port_sel;
    assign data_rd = rd_en & ~port_sel;

    always_comb begin
        rld_go = 1'b0;
        cmr_go = 1'b0;
        ior_go = 1'b0;
        idr_go = 1'b0;
        if (ctrl_wr) begin
            unique case (wdata[7:5])
                SEL_RLD: rld_go = 1'b1;
                SEL_CMR: cmr_go = 1'b1;
                SEL_IOR: ior_go = 1'b1;
                SEL_IDR: idr_go = 1'b1;
                default: ;
            endcase
        end
    end

    assign bp_clr   = rld_go & wdata[0];
    assign zero_go  = rld_go & (wdata[2:1] == 2'b01);
    assign flag_go  = rld_go & (wdata[2:1] == 2'b10);
    assign err_go   = rld_go & (wdata[2:1] == 2'b11);
    assign pre_go   = rld_go & (wdata[4:3] == 2'b01);
    assign latch_go = rld_go & (wdata[4:3] == 2'b10);
    assign psc_go   = rld_go & (wdata[4:3] == 2'b11);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_NORMAL;
            quad_q   <= '0;
            io_en    <= 1'b0;
            io_nidx  <= 1'b0;
            idx_pol  <= 1'b0;
            idx_sync <= 1'b0;
            err_q    <= 1'b0;
            latch_q  <= '0;
            psc_out  <= '0;
        end else begin
            if (cmr_go) begin
                mode_q <= cnt_mode_e'(wdata[2:1]);
                quad_q <= wdata[4:3];
                if (wdata[4:3] == 2'b00) idx_sync <= 1'b0;
            end
            if (ior_go) begin
                io_en   <= wdata[0];
                io_nidx <= wdata[1];
            end
            if (idr_go) begin
                idx_pol  <= wdata[1];
                idx_sync <= wdata[0] & (quad_q != 2'b00);
            end
            if (noise_in)    err_q <= 1'b1;
            else if (err_go) err_q <= 1'b0;
            if (latch_go) latch_q <= cnt_q;
            if (psc_go)   psc_out <= preset_q[BUS_W-1:0];
        end
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [BUS_W-1:0] pre_b;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pre_b <= '0;
            else if (data_wr && bp == PTR_W'(b))
                pre_b <= wdata;
        end
        assign preset_q[b*BUS_W +: BUS_W] = pre_b;
        assign latch_b[b] = latch_q[b*BUS_W +: BUS_W];
    end

    chan_byte_ptr #(.NBYTES(NBYTES)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (bp_clr),
        .step (data_wr | data_rd),
        .ptr  (bp)
    );

    assign strobe_ok = cnt_pulse & io_en;

    chan_index_det u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .index_in (index_in),
        .pol_high (idx_pol),
        .sync_mode(idx_sync),
        .strobe   (strobe_ok),
        .event_o  (idx_evt)
    );

    assign load_pre = pre_go | (idx_evt & ~io_nidx);

    chan_count_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe_ok),
        .dir_up     (cnt_dir),
        .mode       (mode_q),
        .preset     (preset_q),
        .load_zero  (zero_go),
        .load_preset(load_pre),
        .clr_toggles(flag_go),
        .cnt        (cnt_q),
        .bt         (bt_q),
        .ct         (ct_q),
        .ud         (ud_q),
        .halted     (halt_q)
    );

    always_comb begin
        status    = '0;
        status[0] = bt_q;
        status[1] = ct_q;
        status[4] = err_q;
        status[5] = ud_q;
    end

    assign rdata = port_sel ? status : latch_b[bp];
endmodule

// File: rtl/chan_checker.sv
module chan_checker
    import chan_pkg::*;
#(
    parameter int W = 24,
    parameter int NBYTES = 3,
    localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_ok,
    input logic             load_any,
    input logic             ctrl_wr,
    input logic             data_wr,
    input logic             clr_flags,
    input logic             latch_go,
    input cnt_mode_e        mode,
    input logic [W-1:0]     preset,
    input logic [W-1:0]     cnt,
    input logic [W-1:0]     latch,
    input logic             bt,
    input logic             ct,
    input logic             halted,
    input logic [PTR_W-1:0] bp
);
    always_comb begin
        if (rst_n)
            assert_bp_range_R2: assert (int'(bp) < NBYTES);
    end

    assert_latch_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_go |=> latch == $past(cnt));

    assert_toggle_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ok && !clr_flags) |=> ($stable(bt) && $stable(ct)));

    assert_range_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RANGE && cnt <= preset && !load_any && !ctrl_wr && !data_wr)
        |=> cnt <= preset);

    assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !load_any) |=> $stable(cnt));

    assert_modn_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MODN && cnt <= preset && !load_any && !ctrl_wr && !data_wr)
        |=> cnt <= preset);

    assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ok && !load_any) |=> $stable(cnt));
endmodule

bind preset_counter_chan chan_checker #(.W(CNT_W), .NBYTES(NBYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_ok(strobe_ok),
    .load_any (load_pre | zero_go),
    .ctrl_wr  (ctrl_wr),
    .data_wr  (data_wr),
    .clr_flags(flag_go),
    .latch_go (latch_go),
    .mode     (mode_q),
    .preset   (preset_q),
    .cnt      (cnt_q),
    .latch    (latch_q),
    .bt       (bt_q),
    .ct       (ct_q),
    .halted   (halt_q),
    .bp       (bp)
);

// File: tb/sim_preset_counter_chan.sv
module sim_preset_counter_chan;
    localparam logic [23:0] MAXV = 24'hFFFFFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, psc_out;
    logic       cnt_pulse = 1'b0, cnt_dir = 1'b0, index_in = 1'b0, noise_in = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [23:0] m_cnt;
    logic        m_bt, m_ct, m_ud, m_halt;

    preset_counter_chan u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .port_sel(port_sel), .wdata(wdata), .rdata(rdata),
        .cnt_pulse(cnt_pulse), .cnt_dir(cnt_dir), .index_in(index_in),
        .noise_in(noise_in), .psc_out(psc_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; port_sel = sel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; port_sel = sel;
        #2 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic up);
        @(negedge clk);
        cnt_pulse = 1'b1; cnt_dir = up;
        @(negedge clk);
        cnt_pulse = 1'b0;
    endtask

    task automatic set_idx(input logic v);
        @(negedge clk);
        index_in = v;
        @(negedge clk);
    endtask

    task automatic set_preset(input logic [23:0] v);
        wr(1'b1, 8'h01);
        for (int b = 0; b < 3; b++) wr(1'b0, v[8*b +: 8]);
    endtask

    task automatic read_latch(output logic [23:0] v);
        logic [7:0] t;
        for (int b = 0; b < 3; b++) begin
            rd(1'b0, t);
            v[8*b +: 8] = t;
        end
    endtask

    task automatic read_cnt(output logic [23:0] v);
        wr(1'b1, 8'h11);
        read_latch(v);
    endtask

    task automatic read_status(output logic [7:0] v);
        rd(1'b1, v);
    endtask

    task automatic m_step(input logic up, input int mode, input logic [23:0] p);
        logic lim;
        m_ud = up;
        if (m_halt) return;
        if (mode == 1 || mode == 3) lim = up ? (m_cnt >= p) : (m_cnt == 0);
        else                        lim = up ? (m_cnt == MAXV) : (m_cnt == 0);
        if (!lim) begin
            m_cnt = up ? m_cnt + 24'd1 : m_cnt - 24'd1;
        end else if (mode != 1) begin
            if (up) m_ct = ~m_ct; else m_bt = ~m_bt;
            m_cnt = up ? 24'd0 : ((mode == 3) ? p : MAXV);
            if (mode == 2) m_halt = 1'b1;
        end
    endtask

    task automatic run_mode(input int mode, input logic [23:0] s);
        logic [23:0] c;
        logic [7:0]  st;
        string       tag;
        tag = (mode == 0) ? "R5" : (mode == 1) ? "R6" : (mode == 2) ? "R7" : "R8";
        wr(1'b1, 8'h20 | 8'(mode << 1));
        set_preset(s);
        wr(1'b1, 8'h08);
        wr(1'b1, 8'h04);
        m_cnt = s; m_bt = 0; m_ct = 0; m_halt = 0; m_ud = 0;
        for (int i = 0; i < 20; i++) begin
            pulse(i < 8);
            m_step(i < 8, mode, s);
            read_cnt(c);
            chk({tag, " count"}, {8'h0, c}, {8'h0, m_cnt});
            read_status(st);
            chk({tag, " flags"}, {24'h0, st & 8'h23}, {26'h0, m_ud, 3'b0, m_ct, m_bt});
            if (mode == 0)
                chk("R5 25-bit count", {7'h0, st[0] ^ st[1], c}, {7'h0, m_bt ^ m_ct, m_cnt});
        end
        if (mode == 2) begin
            wr(1'b1, 8'h08);
            pulse(1'b1);
            read_cnt(c);
            chk("R7 resume after reload", {8'h0, c}, {8'h0, s + 24'd1});
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] c;
        logic [7:0]  st, t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_status(st);
        chk("R1 reset status", {24'h0, st}, 32'h0);
        chk("R1 reset prescaler", {24'h0, psc_out}, 32'h0);
        read_cnt(c);
        chk("R1 reset count", {8'h0, c}, 32'h0);

        wr(1'b1, 8'h43);

        // R2 byte order and pointer wrap
        set_preset(24'hABCDEF);
        wr(1'b1, 8'h08);
        read_cnt(c);
        chk("R2 lsb-first preset", {8'h0, c}, 32'hABCDEF);
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h11); wr(1'b0, 8'h22); wr(1'b0, 8'h33); wr(1'b0, 8'h44);
        wr(1'b1, 8'h08);
        read_cnt(c);
        chk("R2 write pointer wrap", {8'h0, c}, 32'h332244);
        rd(1'b0, t);
        chk("R2 read pointer wrap", {24'h0, t}, 32'h44);

        // R1 ignored selects
        set_preset(24'h000777);
        wr(1'b1, 8'h88);
        wr(1'b1, 8'hA8);
        wr(1'b1, 8'hEA);
        read_cnt(c);
        chk("R1 bit7 writes ignored", {8'h0, c}, 32'h332244);

        // R4 clear and preset transfer
        wr(1'b1, 8'h02);
        read_cnt(c);
        chk("R4 clear counter", {8'h0, c}, 32'h0);
        wr(1'b1, 8'h08);
        read_cnt(c);
        chk("R4 preset to counter", {8'h0, c}, 32'h777);

        // R3 latch holds until next transfer
        wr(1'b1, 8'h10);
        pulse(1'b1); pulse(1'b1);
        wr(1'b1, 8'h01);
        read_latch(c);
        chk("R3 stale latch", {8'h0, c}, 32'h777);
        read_cnt(c);
        chk("R3 fresh latch", {8'h0, c}, 32'h779);

        // R13 prescaler transfer
        set_preset(24'h00005A);
        wr(1'b1, 8'h18);
        chk("R13 prescaler 0x18", {24'h0, psc_out}, 32'h5A);
        set_preset(24'h0000C3);
        wr(1'b1, 8'h19);
        chk("R13 prescaler 0x19", {24'h0, psc_out}, 32'hC3);
        wr(1'b0, 8'h77);
        wr(1'b1, 8'h08);
        read_cnt(c);
        chk("R13 0x19 resets pointer", {8'h0, c}, 32'h000077);

        // R5..R8 mode sweeps
        run_mode(0, 24'hFFFFFC);
        run_mode(1, 24'h000005);
        run_mode(2, 24'hFFFFFC);
        run_mode(3, 24'h000005);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h04);

        // R14 load versus strobe, latch versus strobe
        set_preset(24'h000100);
        wr(1'b1, 8'h08);
        @(negedge clk);
        wr_en = 1; port_sel = 1; wdata = 8'h08; cnt_pulse = 1; cnt_dir = 1;
        @(negedge clk);
        wr_en = 0; cnt_pulse = 0;
        read_cnt(c);
        chk("R14 load beats strobe", {8'h0, c}, 32'h100);
        @(negedge clk);
        wr_en = 1; port_sel = 1; wdata = 8'h10; cnt_pulse = 1; cnt_dir = 1;
        @(negedge clk);
        wr_en = 0; cnt_pulse = 0;
        wr(1'b1, 8'h01);
        read_latch(c);
        chk("R14 latch before strobe", {8'h0, c}, 32'h100);
        read_cnt(c);
        chk("R14 strobe still counted", {8'h0, c}, 32'h101);

        // R9 disabled strobes
        wr(1'b1, 8'h42);
        pulse(1'b0); pulse(1'b0); pulse(1'b0);
        read_cnt(c);
        chk("R9 disabled count", {8'h0, c}, 32'h101);
        read_status(st);
        chk("R9 direction kept", {31'h0, st[5]}, 32'h1);
        wr(1'b1, 8'h41);
        pulse(1'b0);
        read_status(st);
        chk("R9 direction down", {31'h0, st[5]}, 32'h0);

        // R10 index edge loads
        wr(1'b1, 8'h62);
        set_preset(24'h123456);
        wr(1'b1, 8'h02);
        set_idx(1'b1);
        read_cnt(c);
        chk("R10 rising edge load", {8'h0, c}, 32'h123456);
        pulse(1'b1);
        set_idx(1'b0);
        read_cnt(c);
        chk("R10 falling ignored", {8'h0, c}, 32'h123457);
        set_idx(1'b1);
        wr(1'b1, 8'h60);
        pulse(1'b1);
        set_idx(1'b0);
        read_cnt(c);
        chk("R10 falling edge load", {8'h0, c}, 32'h123456);
        wr(1'b1, 8'h43);
        pulse(1'b1);
        set_idx(1'b1); set_idx(1'b0);
        read_cnt(c);
        chk("R10 index disabled", {8'h0, c}, 32'h123457);

        // R11 synchronous index
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h63);
        wr(1'b1, 8'h41);
        pulse(1'b1);
        set_idx(1'b1);
        read_cnt(c);
        chk("R11 sync rejected", {8'h0, c}, 32'h123456);
        set_idx(1'b0);
        pulse(1'b1);
        wr(1'b1, 8'h28);
        wr(1'b1, 8'h63);
        set_idx(1'b1);
        read_cnt(c);
        chk("R11 no load without strobe", {8'h0, c}, 32'h123457);
        pulse(1'b1);
        read_cnt(c);
        chk("R11 strobe loads", {8'h0, c}, 32'h123456);
        set_idx(1'b0);
        pulse(1'b1);
        read_cnt(c);
        chk("R11 inactive counts", {8'h0, c}, 32'h123457);
        wr(1'b1, 8'h20);
        set_idx(1'b1);
        read_cnt(c);
        chk("R11 sync cleared", {8'h0, c}, 32'h123456);
        set_idx(1'b0);
        wr(1'b1, 8'h43);

        // R12 flag clears and noise
        set_preset(MAXV);
        wr(1'b1, 8'h08);
        pulse(1'b1);
        @(negedge clk); noise_in = 1; @(negedge clk); noise_in = 0;
        read_status(st);
        chk("R12 carry and error set", {24'h0, st}, 32'h32);
        wr(1'b1, 8'h04);
        read_status(st);
        chk("R12 toggles cleared", {24'h0, st}, 32'h30);
        @(negedge clk);
        wr_en = 1; port_sel = 1; wdata = 8'h06; noise_in = 1;
        @(negedge clk);
        wr_en = 0; noise_in = 0;
        read_status(st);
        chk("R12 noise beats clear", {24'h0, st}, 32'h30);
        wr(1'b1, 8'h06);
        read_status(st);
        chk("R12 error cleared", {24'h0, st}, 32'h20);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule